// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output from a small register set. An 8-bit coarse timer with a 2-bit fine counter below it forms a 10-bit time base. The base advances once per prescaler tick, and the prescaler divides the clock by 1, 4 or 16. A period runs from base value zero through the last fine step of the coarse value held in the period register, then starts again. The output rises at the start of each period and falls once the time base reaches the active duty value.

Software can write the duty value at any moment. The generator does not use the new value at once. It copies the value into a shadow register at the next period start, so a period already under way always finishes with the duty it began with. The shadow value can be read on a dedicated output. A separate pulse output marks every Nth period end, which suits a slower update rate such as a servo refresh tick. Clearing the control register stops the generator and drives the output low.

Top module: `pwm10_gen`

## Requirements
- R1: While `rst` is high and after it falls, `pwmOut`, `postPulse` and `dutyLatched` are 0. The generator stays idle until the enable bit is written.
- R2: Registers are written through `wrEn`, `wrAddr` and `wrData`. Address 0 holds the period value PR. Address 1 holds duty bits 9:2. Address 3 holds the postscale count N in bits 3:0. Address 2 is control: bit 7 enables, bits 6:5 select the prescale, bits 1:0 are duty bits 1:0, and bits 4:2 are ignored. While enabled, one period lasts (PR+1)·4·P clocks, where P is 1, 4 or 16 for select codes 0, 1, and 2 or 3.
- R3: With an active duty D where 0 < D < 4·(PR+1), `pwmOut` is high for the first D·P clocks of each period and low for the rest.
- R4: A duty written during a period has no effect on that period. It becomes active at the next period start, and `dutyLatched` shows the active value and changes only at a period start.
- R5: An active duty of 0 keeps `pwmOut` low for the whole period. There is no high pulse at the period start.
- R6: An active duty of 4·(PR+1) or more keeps `pwmOut` high for the whole period.
- R7: A change of prescale select during a period takes effect at the next period start. The running period keeps its old rate.
- R8: Writing the control register with bit 7 clear drives `pwmOut` low by the second clock edge after the write, and keeps it low while disabled.
- R9: `postPulse` is high for exactly the first clock of every (N+1)th period after enabling, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select for the write |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | PWM output |
| dutyLatched | output | 10 | Active (shadow) duty value, read-only |
| postPulse | output | 1 | One-clock pulse every N+1 periods |

## Verification
The assertions check the following on every cycle: the reset state; that the shadow duty changes only while the time base sits at zero; that the output is never high while the shadow duty is zero; that the output rises only at base zero; that a disabling write brings the output low; and that the postscale pulse lasts one clock. Exact period and high-time lengths for each prescale ratio, and the one-period delay of mid-period duty and prescale writes, can only be shown by the bench's scenarios. The bench compares the output cycle by cycle with a computed waveform for directed and random settings.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  // Register select codes on the write port
  typedef enum logic [1:0] {
    REG_PERIOD  = 2'd0,
    REG_DUTY_HI = 2'd1,
    REG_CTRL    = 2'd2,
    REG_POST    = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic halt;     // generator disabled: clear base and output
    logic load;     // period start: clear base, latch duty, set output
    logic advance;  // time base step inside a period
  } pwmStrobe_t;

  localparam int PSC_W = 4;

  // Last prescaler count for a select code (ratio minus one)
  function automatic logic [PSC_W-1:0] pscLast(input logic [1:0] sel);
    case (sel)
      2'd0:    return PSC_W'(0);
      2'd1:    return PSC_W'(3);
      default: return PSC_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/pwm10_ctrl.sv
module pwm10_ctrl
  import pwm10_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2,
  parameter int POST_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wrEn,
  input  logic [1:0]                wrAddr,
  input  logic [TMR_W-1:0]          wrData,
  input  logic                      periodEnd,
  output logic [TMR_W-1:0]          periodReg,
  output logic [TMR_W+FINE_W-1:0]   dutyReg,
  output pwmStrobe_t                strobe,
  output logic                      postPulse
);

  localparam int ENA_BIT = TMR_W - 1;
  localparam int PSC_LSB = TMR_W - 3;

  logic [TMR_W-1:0]  periodQ;
  logic [TMR_W-1:0]  dutyHiQ;
  logic [FINE_W-1:0] dutyLoQ;
  logic [1:0]        pscSelQ;
  logic              enableQ;
  logic [POST_W-1:0] postRatioQ;

  logic              running;
  logic [1:0]        activeSel;
  logic [PSC_W-1:0]  pscCnt;
  logic [POST_W-1:0] postCnt;
  logic              tick;
  logic              postHit;

  assign periodReg = periodQ;
  assign dutyReg   = {dutyHiQ, dutyLoQ};

  assign tick    = running && (pscCnt == pscLast(activeSel));
  assign postHit = (postCnt >= postRatioQ);

  always_comb begin
    strobe.halt    = !enableQ;
    strobe.load    = enableQ && (!running || (tick && periodEnd));
    strobe.advance = enableQ && tick && !periodEnd;
  end

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      periodQ    <= '0;
      dutyHiQ    <= '0;
      dutyLoQ    <= '0;
      pscSelQ    <= '0;
      enableQ    <= 1'b0;
      postRatioQ <= '0;
    end else if (wrEn) begin
      case (regSel_e'(wrAddr))
        REG_PERIOD:  periodQ <= wrData;
        REG_DUTY_HI: dutyHiQ <= wrData;
        REG_CTRL: begin
          enableQ <= wrData[ENA_BIT];
          pscSelQ <= wrData[PSC_LSB +: 2];
          dutyLoQ <= wrData[FINE_W-1:0];
        end
        default:     postRatioQ <= wrData[POST_W-1:0];
      endcase
    end
  end

  // Sequencing: prescaler, run state, postscaler
  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      activeSel <= '0;
      pscCnt    <= '0;
      postCnt   <= '0;
      postPulse <= 1'b0;
    end else if (strobe.halt) begin
      running   <= 1'b0;
      pscCnt    <= '0;
      postCnt   <= '0;
      postPulse <= 1'b0;
    end else if (strobe.load) begin
      running   <= 1'b1;
      activeSel <= pscSelQ;
      pscCnt    <= '0;
      postPulse <= running && postHit;
      if (!running || postHit) postCnt <= '0;
      else                     postCnt <= postCnt + 1'b1;
    end else begin
      postPulse <= 1'b0;
      if (running) begin
        if (tick) pscCnt <= '0;
        else      pscCnt <= pscCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm10_datapath.sv
module pwm10_datapath
  import pwm10_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pwmStrobe_t               strobe,
  input  logic [TMR_W-1:0]         periodReg,
  input  logic [TMR_W+FINE_W-1:0]  dutyReg,
  output logic [TMR_W+FINE_W-1:0]  baseCount,
  output logic [TMR_W+FINE_W-1:0]  shadowDuty,
  output logic                     pwmOut,
  output logic                     periodEnd
);

  localparam int BASE_W = TMR_W + FINE_W;

  logic [BASE_W-1:0] baseQ;
  logic [BASE_W-1:0] shadowQ;
  logic [BASE_W-1:0] baseNext;
  logic [BASE_W-1:0] lastBase;
  logic              outQ;

  // Coarse timer in the upper bits, fine counter in the lower FINE_W bits
  assign lastBase  = {periodReg, {FINE_W{1'b1}}};
  assign periodEnd = (baseQ >= lastBase);
  assign baseNext  = baseQ + 1'b1;

  assign baseCount  = baseQ;
  assign shadowDuty = shadowQ;
  assign pwmOut     = outQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ   <= '0;
      shadowQ <= '0;
      outQ    <= 1'b0;
    end else if (strobe.halt) begin
      baseQ <= '0;
      outQ  <= 1'b0;
    end else if (strobe.load) begin
      baseQ   <= '0;
      shadowQ <= dutyReg;
      outQ    <= (dutyReg != '0);
    end else if (strobe.advance) begin
      baseQ <= baseNext;
      if (baseNext == shadowQ) outQ <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2,
  parameter int POST_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [TMR_W-1:0]         wrData,
  output logic                     pwmOut,
  output logic [TMR_W+FINE_W-1:0]  dutyLatched,
  output logic                     postPulse
);

  localparam int BASE_W = TMR_W + FINE_W;

  pwmStrobe_t        strobe;
  logic [TMR_W-1:0]  periodReg;
  logic [BASE_W-1:0] dutyReg;
  logic [BASE_W-1:0] baseCount;
  logic              periodEnd;

  pwm10_ctrl #(
    .TMR_W (TMR_W),
    .FINE_W(FINE_W),
    .POST_W(POST_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .periodEnd(periodEnd),
    .periodReg(periodReg),
    .dutyReg  (dutyReg),
    .strobe   (strobe),
    .postPulse(postPulse)
  );

  pwm10_datapath #(
    .TMR_W (TMR_W),
    .FINE_W(FINE_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .periodReg (periodReg),
    .dutyReg   (dutyReg),
    .baseCount (baseCount),
    .shadowDuty(dutyLatched),
    .pwmOut    (pwmOut),
    .periodEnd (periodEnd)
  );

endmodule

// File: rtl/pwm10_checker.sv
module pwm10_checker #(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wrEn,
  input logic [1:0]               wrAddr,
  input logic [TMR_W-1:0]         wrData,
  input logic                     pwmOut,
  input logic [TMR_W+FINE_W-1:0]  dutyLatched,
  input logic [TMR_W+FINE_W-1:0]  baseCount,
  input logic                     postPulse
);

  localparam int ENA_BIT = TMR_W - 1;

  logic rstQ = 1'b0;

  // R1: one edge after reset was seen, outputs are cleared
  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rstQ) begin
      p_reset_clear_r1: assert (!pwmOut && !postPulse && dutyLatched == '0)
        else $error("reset state not cleared");
    end
  end

  // R4: shadow duty only changes at a period start
  p_shadow_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(dutyLatched) |-> baseCount == '0);

  // R5: zero active duty never gives a high output
  p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (rst)
    dutyLatched == '0 |-> !pwmOut);

  // R3: the output only rises at the first step of a period
  p_rise_at_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pwmOut) |-> baseCount == '0);

  // R8: a disabling control write brings the output low
  p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 2'd2 && !wrData[ENA_BIT]) |=> ##1 !pwmOut);

  // R9: the postscale pulse lasts one clock
  p_post_single_r9: assert property (@(posedge clk) disable iff (rst)
    postPulse |=> !postPulse);

endmodule

bind pwm10_gen pwm10_checker #(
  .TMR_W (TMR_W),
  .FINE_W(FINE_W)
) u_check (
  .clk        (clk),
  .rst        (rst),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .pwmOut     (pwmOut),
  .dutyLatched(dutyLatched),
  .baseCount  (baseCount),
  .postPulse  (postPulse)
);

// File: tb/pwm10_gen_bench.sv
module pwm10_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       pwmOut;
  logic [9:0] dutyLatched;
  logic       postPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pwm10_gen u_pwm10_gen (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .pwmOut     (pwmOut),
    .dutyLatched(dutyLatched),
    .postPulse  (postPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pdiv(input int sel);
    return (sel == 0) ? 1 : ((sel == 1) ? 4 : 16);
  endfunction

  function automatic int plenOf(input int pr, input int sel);
    return (pr + 1) * 4 * pdiv(sel);
  endfunction

  function automatic int hiOf(input int pr, input int duty, input int sel);
    int span = 4 * (pr + 1);
    return ((duty < span) ? duty : span) * pdiv(sel);
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = a;
    wrData = d;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  function automatic logic [7:0] ctrlWord(input int sel, input int duty);
    logic [1:0] s = 2'(sel);
    logic [9:0] d = 10'(duty);
    return {1'b1, s, 3'b000, d[1:0]};
  endfunction

  // Disable, program, enable; returns at the negedge of the first period cycle
  task automatic startRun(input int pr, input int duty, input int sel, input int post);
    logic [9:0] d = 10'(duty);
    writeReg(2'd2, 8'd0);
    writeReg(2'd0, 8'(pr));
    writeReg(2'd1, d[9:2]);
    writeReg(2'd3, 8'(post));
    writeReg(2'd2, ctrlWord(sel, duty));
    @(negedge clk);
  endtask

  // Compare output (and optionally postPulse) with the computed waveform
  task automatic runSample(input int total, input int plen0, input int hi0,
                           input int plen1, input int hi1, input int postN,
                           input string req);
    int pos = 0;
    int per = 0;
    int bad = 0;
    int badPost = 0;
    for (int i = 0; i < total; i++) begin
      int plen = (per == 0) ? plen0 : plen1;
      int hi   = (per == 0) ? hi0 : hi1;
      bit expOut = (pos < hi);
      if (pwmOut !== expOut) bad++;
      if (postN >= 0) begin
        bit expP = (per > 0) && (pos == 0) && ((per % (postN + 1)) == 0);
        if (postPulse !== expP) badPost++;
      end
      pos++;
      if (pos == plen) begin
        pos = 0;
        per++;
      end
      @(negedge clk);
    end
    check(bad == 0, {req, " waveform mismatched cycles"}, bad, 0);
    if (postN >= 0) check(badPost == 0, "R9 postPulse mismatched cycles", badPost, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int highs;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R1 pwmOut in reset", int'(pwmOut), 0);
    check(dutyLatched == 10'd0, "R1 dutyLatched in reset", int'(dutyLatched), 0);
    check(postPulse == 1'b0, "R1 postPulse in reset", int'(postPulse), 0);
    rst = 1'b0;
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmOut || postPulse) highs++;
    end
    check(highs == 0, "R1 idle after reset", highs, 0);

    // R2 R3: basic period and high time, no prescale
    startRun(4, 7, 0, 0);
    runSample(3 * plenOf(4, 0), plenOf(4, 0), hiOf(4, 7, 0),
              plenOf(4, 0), hiOf(4, 7, 0), -1, "R2 R3 pr4 d7 p1");

    // R3: smallest nonzero duty with prescale 4
    startRun(2, 1, 1, 0);
    runSample(3 * plenOf(2, 1), plenOf(2, 1), hiOf(2, 1, 1),
              plenOf(2, 1), hiOf(2, 1, 1), -1, "R3 duty1 p4");

    // R5: zero duty
    startRun(7, 0, 1, 0);
    check(dutyLatched == 10'd0, "R5 latched zero", int'(dutyLatched), 0);
    runSample(2 * plenOf(7, 1), plenOf(7, 1), 0, plenOf(7, 1), 0, -1, "R5 zero duty");

    // R6: duty equal to the span, and duty far above it with prescale 16
    startRun(7, 32, 0, 0);
    runSample(3 * plenOf(7, 0), plenOf(7, 0), plenOf(7, 0),
              plenOf(7, 0), plenOf(7, 0), -1, "R6 duty=span");
    startRun(3, 1023, 2, 0);
    runSample(2 * plenOf(3, 2), plenOf(3, 2), plenOf(3, 2),
              plenOf(3, 2), plenOf(3, 2), -1, "R6 duty1023 p16");

    // R2: largest period
    startRun(255, 600, 0, 0);
    runSample(2 * plenOf(255, 0), plenOf(255, 0), hiOf(255, 600, 0),
              plenOf(255, 0), hiOf(255, 600, 0), -1, "R2 pr255");

    // R9: postscale pulse every 3 periods (select code 3 also means 16)
    startRun(1, 3, 3, 2);
    runSample(10 * plenOf(1, 3), plenOf(1, 3), hiOf(1, 3, 3),
              plenOf(1, 3), hiOf(1, 3, 3), 2, "R9 R2 post2 sel3");

    // R4: mid-period duty write affects only the next period
    startRun(9, 20, 0, 0);
    check(dutyLatched == 10'd20, "R4 latched at start", int'(dutyLatched), 20);
    fork
      runSample(3 * 40, 40, 20, 40, 32, -1, "R4 mid-period duty");
      begin
        repeat (15) @(negedge clk);
        writeReg(2'd1, 8'd8);
        check(dutyLatched == 10'd20, "R4 shadow held mid-period", int'(dutyLatched), 20);
      end
    join
    check(dutyLatched == 10'd32, "R4 shadow updated", int'(dutyLatched), 32);

    // R7: mid-period prescale change applies at next period
    startRun(3, 6, 0, 0);
    fork
      runSample(16 + 2 * 64, 16, 6, 64, 24, -1, "R7 prescale change");
      begin
        repeat (5) @(negedge clk);
        writeReg(2'd2, ctrlWord(1, 6));
      end
    join

    // R8: disabling clears the output and holds it low
    startRun(2, 1023, 0, 0);
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b1, "R8 running high before disable", int'(pwmOut), 1);
    writeReg(2'd2, 8'h00);
    @(negedge clk);
    check(pwmOut == 1'b0, "R8 low after disable", int'(pwmOut), 0);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
    check(highs == 0, "R8 stays low while disabled", highs, 0);

    // Random settings: R2 R3 R5 R6 R9
    for (int n = 0; n < 8; n++) begin
      int pr   = $urandom_range(15, 0);
      int sel  = $urandom_range(3, 0);
      int duty = $urandom_range(4 * (pr + 1) + 3, 0);
      int post = $urandom_range(3, 0);
      int pl   = plenOf(pr, sel);
      int hi   = hiOf(pr, duty, sel);
      startRun(pr, duty, sel, post);
      runSample((post + 1) * 2 * pl, pl, hi, pl, hi, post, "R2 R3 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule